// File: doc/BRIEF.md
# Function Request Mailbox

This block sits between a host processor and a coprocessor's execution unit. The host programs a request through a small word-addressed register window. It first reads a state word, then fills as many as seven 16-bit operand slots, and finally writes an opcode. The opcode write launches the function. The block freezes the operand slots for the whole time the function runs. It offers opcode and operands to the execution unit on a valid/ready request channel, and it accepts the answer on a valid/ready response channel. The answer is ten result words plus an optional fault report.

When the function ends, the block records the outcome in the state word. It keeps the fault report in a separate status word and raises its interrupt line for exactly one clock. The host is free to do other work while the function runs. A second opcode written during that time is dropped and remembered in a sticky overrun bit.

On the request channel the block holds `req_valid`, opcode and operands steady until `req_ready` is seen high at a clock edge. On the response channel, `resp_ready` is high only while a response is awaited. A response offered at any other time waits, so the executor must hold `resp_valid` and its payload until the handshake. `host_rdata` is a combinational view of the addressed word. `host_rd_en` matters only for the side effect of reading the state word.

Top module: `fnreq_mailbox`

## Requirements
- R1: After reset the state word reads 0 (idle, no overrun), `irq`, `req_valid` and `resp_ready` are 0, and every operand and result slot reads 0.
- R2: Operand slot k (k = 0..6) is written and read back at word address 3+k while no function is in progress.
- R3: Writing word address 2 while idle or finished launches a function with opcode `host_wdata[7:0]`. From the next cycle `req_valid` is high with that opcode and the operand slots, and this request holds steady until accepted by `req_ready`.
- R4: Operand writes while a function is in progress (state busy) are ignored; the slots keep their earlier values.
- R5: An opcode write while busy is ignored and sets the overrun flag, state word bit 2, which stays set until reset.
- R6: Running a function never changes the operand slots.
- R7: On the response handshake, the ten result words are captured and read at word addresses 16+j (j = 0..9).
- R8: Completion drives `irq` high for one cycle, in the first cycle the state word bits [1:0] show 2 (completed) or 3 (faulted). The state word reads 1 while busy.
- R9: The fault status word at address 1 holds the level in bits [5:4] and the type in bits [3:0]. Level codes are 00 context, 01 process group 1, 10 process group 2, and 11 processor. A faulted response stores its level and type there; a clean completion clears the word.
- R10: An opcode at or above NUM_OPS (default 32) does not reach the executor. It completes in the cycle after the write, in faulted state, with fault word level 00 and type 0xE.
- R11: Reading the state word while it shows completed or faulted returns it to idle; reading it while busy changes nothing.
- R12: `resp_ready` is high only after the request was accepted and before the response arrives. It is never high together with `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe (side effect on the state word) |
| host_addr | input | 5 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Addressed word, combinational |
| irq | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Request offered to executor |
| req_ready | input | 1 | Executor accepts request |
| req_opcode | output | 8 | Latched opcode |
| req_operands | output | 112 | Seven operand words, slot k at bits [16k+15:16k] |
| resp_valid | input | 1 | Executor offers a response |
| resp_ready | output | 1 | Block awaits a response |
| resp_results | input | 160 | Ten result words, slot j at bits [16j+15:16j] |
| resp_fault | input | 1 | Response reports a fault |
| resp_fault_level | input | 2 | Fault level code |
| resp_fault_type | input | 4 | Fault type within the level |

## Verification
The bench targets operand writes and opcode writes that land while a function is running. A design that lets these through would corrupt operands the executor still uses, or would start a second launch. It also holds the executor's request ready low for several cycles. A block that drops or changes its request without a handshake then shows a wrong captured opcode. An out-of-range opcode must fault at once without touching the executor, and a faulted completion must carry its level and type into the status word. The bench also reads the state word both during and after execution, so that a clear-on-read that fires while busy, or fails to fire once done, shows up as a wrong state value.

// File: rtl/fnreq_pkg.sv
package fnreq_pkg;
  typedef enum logic [2:0] {
    FS_IDLE,
    FS_ISSUE,
    FS_WAIT,
    FS_DONE,
    FS_FAULT
  } fsm_t;

  localparam logic [1:0] VIS_IDLE = 2'd0;
  localparam logic [1:0] VIS_BUSY = 2'd1;
  localparam logic [1:0] VIS_OK   = 2'd2;
  localparam logic [1:0] VIS_FLT  = 2'd3;

  localparam logic [1:0] LVL_CONTEXT = 2'b00;
  localparam logic [3:0] FT_BAD_OPCODE = 4'hE;

  typedef struct packed {
    logic [1:0] level;
    logic [3:0] ftype;
  } fault_t;
endpackage

// File: rtl/fnreq_operands.sv
module fnreq_operands #(
  parameter int DW = 16,
  parameter int N  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  wr_sel,
  input  logic [DW-1:0] wdata,
  output logic [N*DW-1:0] opnd_flat
);
  for (genvar k = 0; k < N; k++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)         slot_q <= '0;
      else if (wr_sel[k]) slot_q <= wdata;
    end
    assign opnd_flat[k*DW +: DW] = slot_q;
  end
endmodule

// File: rtl/fnreq_results.sv
module fnreq_results #(
  parameter int DW = 16,
  parameter int N  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [N*DW-1:0] res_in,
  output logic [N*DW-1:0] res_flat
);
  for (genvar j = 0; j < N; j++) begin : g_res
    logic [DW-1:0] res_q;
    always_ff @(posedge clk) begin
      if (!rst_n)       res_q <= '0;
      else if (capture) res_q <= res_in[j*DW +: DW];
    end
    assign res_flat[j*DW +: DW] = res_q;
  end
endmodule

// File: rtl/fnreq_ctrl.sv
module fnreq_ctrl
  import fnreq_pkg::*;
#(
  parameter int OPC_W   = 8,
  parameter int NUM_OPS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opc_write,
  input  logic [OPC_W-1:0] opc_in,
  input  logic             state_rd,
  input  logic             req_ready,
  input  logic             resp_valid,
  input  logic             resp_fault,
  input  fault_t           resp_code,
  output logic             busy,
  output logic [1:0]       vis_state,
  output logic             irq,
  output logic             overrun,
  output fault_t           fault_q,
  output logic             req_valid,
  output logic             resp_ready,
  output logic             res_capture,
  output logic [OPC_W-1:0] opcode_q
);
  fsm_t st_q, st_d;
  logic opc_defined;
  logic finish;

  assign busy        = (st_q == FS_ISSUE) || (st_q == FS_WAIT);
  assign req_valid   = (st_q == FS_ISSUE);
  assign resp_ready  = (st_q == FS_WAIT);
  assign res_capture = resp_ready && resp_valid;
  assign opc_defined = {1'b0, opc_in} < (OPC_W+1)'(NUM_OPS);

  always_comb begin
    case (st_q)
      FS_ISSUE, FS_WAIT: vis_state = VIS_BUSY;
      FS_DONE:           vis_state = VIS_OK;
      FS_FAULT:          vis_state = VIS_FLT;
      default:           vis_state = VIS_IDLE;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    finish = 1'b0;
    case (st_q)
      FS_ISSUE: if (req_ready) st_d = FS_WAIT;
      FS_WAIT: begin
        if (resp_valid) begin
          st_d   = resp_fault ? FS_FAULT : FS_DONE;
          finish = 1'b1;
        end
      end
      default: begin
        if (opc_write) begin
          st_d   = opc_defined ? FS_ISSUE : FS_FAULT;
          finish = !opc_defined;
        end else if (state_rd && (st_q != FS_IDLE)) begin
          st_d = FS_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= FS_IDLE;
      irq      <= 1'b0;
      overrun  <= 1'b0;
      fault_q  <= '0;
      opcode_q <= '0;
    end else begin
      st_q <= st_d;
      irq  <= finish;
      if (opc_write && busy) overrun <= 1'b1;
      if (opc_write && !busy) opcode_q <= opc_in;
      if (opc_write && !busy && !opc_defined)
        fault_q <= '{level: LVL_CONTEXT, ftype: FT_BAD_OPCODE};
      else if (res_capture)
        fault_q <= resp_fault ? resp_code : '0;
    end
  end
endmodule

// File: rtl/fnreq_mailbox.sv
module fnreq_mailbox
  import fnreq_pkg::*;
#(
  parameter int DW       = 16,
  parameter int ADDR_W   = 5,
  parameter int OPC_W    = 8,
  parameter int NUM_OPND = 7,
  parameter int NUM_RES  = 10,
  parameter int NUM_OPS  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_wr_en,
  input  logic                   host_rd_en,
  input  logic [ADDR_W-1:0]      host_addr,
  input  logic [DW-1:0]          host_wdata,
  output logic [DW-1:0]          host_rdata,
  output logic                   irq,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [OPC_W-1:0]       req_opcode,
  output logic [NUM_OPND*DW-1:0] req_operands,
  input  logic                   resp_valid,
  output logic                   resp_ready,
  input  logic [NUM_RES*DW-1:0]  resp_results,
  input  logic                   resp_fault,
  input  logic [1:0]             resp_fault_level,
  input  logic [3:0]             resp_fault_type
);
  localparam int ST_ADDR   = 0;
  localparam int FLT_ADDR  = 1;
  localparam int OPC_ADDR  = 2;
  localparam int OPND_BASE = 3;
  localparam int RES_BASE  = 16;

  logic              busy;
  logic [1:0]        vis_state;
  logic              overrun;
  fault_t            fault_q;
  logic              res_capture;
  logic [NUM_OPND-1:0] wr_sel;
  logic [NUM_RES*DW-1:0] res_flat;
  logic              opc_write;
  logic              state_rd;
  logic              unused_wdata;

  assign opc_write    = host_wr_en && (host_addr == ADDR_W'(OPC_ADDR));
  assign state_rd     = host_rd_en && (host_addr == ADDR_W'(ST_ADDR));
  assign unused_wdata = ^host_wdata[DW-1:OPC_W];

  for (genvar k = 0; k < NUM_OPND; k++) begin : g_sel
    assign wr_sel[k] = host_wr_en && !busy &&
                       (host_addr == ADDR_W'(OPND_BASE + k));
  end

  fnreq_operands #(.DW(DW), .N(NUM_OPND)) u_opnd (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_sel    (wr_sel),
    .wdata     (host_wdata),
    .opnd_flat (req_operands)
  );

  fnreq_results #(.DW(DW), .N(NUM_RES)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (res_capture),
    .res_in   (resp_results),
    .res_flat (res_flat)
  );

  fnreq_ctrl #(.OPC_W(OPC_W), .NUM_OPS(NUM_OPS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .opc_write   (opc_write),
    .opc_in      (host_wdata[OPC_W-1:0]),
    .state_rd    (state_rd),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .resp_fault  (resp_fault),
    .resp_code   ('{level: resp_fault_level, ftype: resp_fault_type}),
    .busy        (busy),
    .vis_state   (vis_state),
    .irq         (irq),
    .overrun     (overrun),
    .fault_q     (fault_q),
    .req_valid   (req_valid),
    .resp_ready  (resp_ready),
    .res_capture (res_capture),
    .opcode_q    (req_opcode)
  );

  always_comb begin
    host_rdata = '0;
    if (host_addr == ADDR_W'(ST_ADDR))
      host_rdata = {{(DW-3){1'b0}}, overrun, vis_state};
    else if (host_addr == ADDR_W'(FLT_ADDR))
      host_rdata = {{(DW-6){1'b0}}, fault_q};
    for (int k = 0; k < NUM_OPND; k++)
      if (host_addr == ADDR_W'(OPND_BASE + k))
        host_rdata = req_operands[k*DW +: DW];
    for (int j = 0; j < NUM_RES; j++)
      if (host_addr == ADDR_W'(RES_BASE + j))
        host_rdata = res_flat[j*DW +: DW];
  end
endmodule

// File: rtl/fnreq_mailbox_chk.sv
module fnreq_mailbox_chk #(
  parameter int OPC_W  = 8,
  parameter int OPND_W = 112
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              busy,
  input logic [1:0]        vis_state,
  input logic              req_valid,
  input logic              req_ready,
  input logic [OPC_W-1:0]  req_opcode,
  input logic [OPND_W-1:0] req_operands,
  input logic              resp_ready
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_opcode) && $stable(req_operands)); // R3
  AST_OPND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(req_operands))); // R4
  AST_IRQ_DONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> vis_state[1] && !busy); // R8
  AST_END_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq); // R8
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !resp_ready); // R12
endmodule

bind fnreq_mailbox fnreq_mailbox_chk #(.OPC_W(OPC_W), .OPND_W(NUM_OPND*DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq          (irq),
  .busy         (busy),
  .vis_state    (vis_state),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_opcode   (req_opcode),
  .req_operands (req_operands),
  .resp_ready   (resp_ready)
);

// File: tb/fnreq_mailbox_tb_top.sv
module fnreq_mailbox_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         host_wr_en = 1'b0;
  logic         host_rd_en = 1'b0;
  logic [4:0]   host_addr = '0;
  logic [15:0]  host_wdata = '0;
  logic [15:0]  host_rdata;
  logic         irq;
  logic         req_valid;
  logic         req_ready = 1'b0;
  logic [7:0]   req_opcode;
  logic [111:0] req_operands;
  logic         resp_valid = 1'b0;
  logic         resp_ready;
  logic [159:0] resp_results = '0;
  logic         resp_fault = 1'b0;
  logic [1:0]   resp_fault_level = '0;
  logic [3:0]   resp_fault_type = '0;

  always #2 clk = ~clk;

  fnreq_mailbox dut_i (.*);

  localparam logic [7:0] FLT_OP = 8'h09;
  // {opcode, exec delay, accept delay, operand count}
  localparam logic [31:0] VEC [6] = '{
    {8'h03, 8'd2, 8'd0, 8'd7},
    {8'h11, 8'd0, 8'd3, 8'd2},
    {FLT_OP, 8'd5, 8'd1, 8'd1},
    {8'h1F, 8'd7, 8'd2, 8'd0},
    {8'h00, 8'd1, 8'd0, 8'd4},
    {FLT_OP, 8'd0, 8'd0, 8'd3}
  };

  int n_chk = 0;
  int n_bad = 0;
  int acc_dly = 0;
  int exe_dly = 0;
  logic [7:0]  cap_op;
  logic [15:0] opnd_m [7];
  logic [15:0] rd;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] res_of(input logic [7:0] op, input int j);
    return opnd_m[j % 7] + 16'(op) * 16'(j + 1);
  endfunction

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic rdw(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(posedge clk);
    @(negedge clk);
    host_rd_en = 1'b0;
  endtask

  // stub executor
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid) begin
        chk("R12 no resp_ready while request pending", 32'(resp_ready), 32'd0);
        repeat (acc_dly) @(negedge clk);
        chk("R3 request held under back-pressure", 32'(req_valid), 32'd1);
        cap_op = req_opcode;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        repeat (exe_dly) @(negedge clk);
        for (int j = 0; j < 10; j++)
          resp_results[j*16 +: 16] = req_operands[(j % 7)*16 +: 16] + 16'(cap_op) * 16'(j + 1);
        resp_fault       = (cap_op == FLT_OP);
        resp_fault_level = 2'b10;
        resp_fault_type  = req_operands[3:0];
        resp_valid = 1'b1;
        while (!resp_ready) @(negedge clk);
        @(negedge clk);
        resp_valid = 1'b0;
        resp_fault = 1'b0;
      end
    end
  end

  task automatic wait_irq(input string req);
    int c;
    c = 0;
    while (!irq && c < 2000) begin @(negedge clk); c++; end
    chk(req, 32'(irq), 32'd1);
    @(negedge clk);
    chk("R8 irq is a single-cycle pulse", 32'(irq), 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 7; k++) opnd_m[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rdw(5'd0, rd);  chk("R1 state after reset", 32'(rd), 32'h0);
    rdw(5'd16, rd); chk("R1 result 0 after reset", 32'(rd), 32'h0);
    rdw(5'd3, rd);  chk("R1 operand 0 after reset", 32'(rd), 32'h0);
    chk("R1 irq/req_valid/resp_ready after reset", {29'd0, irq, req_valid, resp_ready}, 32'h0);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] op;
      op = VEC[v][31:24];
      exe_dly = int'(VEC[v][23:16]);
      acc_dly = int'(VEC[v][15:8]);
      rdw(5'd0, rd); chk("R11 idle before request", 32'(rd[1:0]), 32'd0);
      for (int k = 0; k < int'(VEC[v][7:0]); k++) begin
        opnd_m[k] = 16'h1000 * 16'(v + 1) + 16'h0111 * 16'(k) + 16'(v);
        wr(5'(3 + k), opnd_m[k]);
      end
      for (int k = 0; k < 7; k++) begin
        rdw(5'(3 + k), rd); chk("R2 operand readback", 32'(rd), 32'(opnd_m[k]));
      end
      wr(5'd2, {8'h00, op});
      wait_irq("R8 irq on completion");
      chk("R3 executor saw opcode", 32'(cap_op), 32'(op));
      rdw(5'd1, rd);
      chk("R9 fault status word", 32'(rd),
          (op == FLT_OP) ? {26'd0, 2'b10, opnd_m[0][3:0]} : 32'h0);
      for (int j = 0; j < 10; j++) begin
        rdw(5'(16 + j), rd); chk("R7 result slot", 32'(rd), 32'(res_of(op, j)));
      end
      for (int k = 0; k < 7; k++) begin
        rdw(5'(3 + k), rd); chk("R6 operand unchanged by execution", 32'(rd), 32'(opnd_m[k]));
      end
      rdw(5'd0, rd); chk("R8 completion state", 32'(rd), (op == FLT_OP) ? 32'd3 : 32'd2);
      rdw(5'd0, rd); chk("R11 state read clears to idle", 32'(rd), 32'd0);
    end

    // R10 undefined opcode
    wr(5'd2, 16'h00C8);
    chk("R10 immediate irq for undefined opcode", 32'(irq), 32'd1);
    chk("R10 no request for undefined opcode", 32'(req_valid), 32'd0);
    rdw(5'd1, rd); chk("R10 context-level bad-opcode fault", 32'(rd), 32'h000E);
    rdw(5'd0, rd); chk("R10 faulted state", 32'(rd), 32'd3);
    rdw(5'd0, rd); chk("R11 cleared after fault read", 32'(rd), 32'd0);

    // R4/R5/R11 busy corner cases
    exe_dly = 30; acc_dly = 0;
    wr(5'd2, 16'h0005);
    wr(5'd3, 16'hDEAD);
    rdw(5'd3, rd); chk("R4 operand write ignored while busy", 32'(rd), 32'(opnd_m[0]));
    wr(5'd2, 16'h0007);
    rdw(5'd0, rd); chk("R5 overrun set, R11 busy unaffected by read", 32'(rd), 32'h5);
    rdw(5'd0, rd); chk("R11 still busy after read", 32'(rd), 32'h5);
    wait_irq("R8 irq after overrun case");
    chk("R5 second opcode dropped", 32'(cap_op), 32'h05);
    rdw(5'd0, rd); chk("R5 overrun sticky at completion", 32'(rd), 32'h6);
    rdw(5'd0, rd); chk("R5 overrun sticky when idle", 32'(rd), 32'h4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule